// File: doc/BRIEF.md
# TDM Time-Slot Serial Port

This block connects a processor-side byte stream to a serial time-division-multiplexed line shared by telephone codecs or DSPs. A frame has between 1 and 128 slots, each carrying one byte sent MSB first. A frame-sync marker fixes where slot 0 begins. Two per-slot enable vectors, one for receive and one for transmit, pick the slots the port takes part in. These slots can be scattered across the frame, and the two directions are set independently.

The serial bit clock, the receive line and the external sync are oversampled in the system clock domain. Edge strobes derived from them advance the bit and slot counters. Each completed active receive slot yields one byte, tagged with its slot number. Each active transmit slot pulls one byte from a valid/ready stream. The transmit line is paired with an output enable, which the pad logic uses to tri-state the line in slots the port does not own.

Frame sync can be generated by the block as a one-bit-wide pulse. It can also be taken from an external pin. In that case the port stays idle until the first pulse arrives, and it realigns on every later pulse.

Top module: `tdm_slot_port`

## Requirements
- R1: While rst_ni is low, rx_valid_o, tx_ready_o, tdm_tx_o, tdm_tx_oe_o and fs_o are all 0.
- R2: The frame length is cfg_last_slot_i + 1 slots (cfg_last_slot_i from 0 to 127). After the last slot the count wraps to slot 0, and rx_slot_o never exceeds cfg_last_slot_i.
- R3: Each slot carries its byte MSB first (bit 7 first, bit 0 last). The receive line is sampled on the falling edge of bclk_i.
- R4: When an active receive slot completes, rx_valid_o pulses for one clk_i cycle. The pulse carries the assembled byte on rx_data_o and the slot index on rx_slot_o, and bytes appear in slot order.
- R5: A slot whose rx_mask_i bit is 0 produces no rx_valid_o pulse.
- R6: At the start of each active transmit slot, tx_ready_o pulses for one clk_i cycle. The byte on tx_data_i is taken if tx_valid_i is high, and its bits leave on tdm_tx_o MSB first. tdm_tx_o and tdm_tx_oe_o change only after a rising edge of bclk_i.
- R7: tdm_tx_oe_o is high for the whole of every active transmit slot. It is low, with tdm_tx_o at 0, for the whole of every slot whose tx_mask_i bit is 0.
- R8: If tx_valid_i is low when an active transmit slot starts, the slot carries 0x00 and no stream byte is consumed.
- R9: With cfg_ext_sync_i = 0, fs_o is high for exactly the final bit period of every frame (slot cfg_last_slot_i, bit 0). This gives one pulse per (cfg_last_slot_i + 1) × 8 bit clocks. With cfg_ext_sync_i = 1, fs_o stays 0.
- R10: With cfg_ext_sync_i = 1, fs_i high at a falling bclk_i edge makes the next bit period bit 7 of slot 0, including in the middle of a frame. A receive slot cut short this way produces no byte.
- R11: With cfg_ext_sync_i = 1, the port is idle after reset until the first fs_i pulse: tdm_tx_oe_o low, no tx_ready_o and no rx_valid_o.
- R12: Bit n of rx_mask_i and bit n of tx_mask_i enable slot n. The two vectors are independent and may select non-contiguous slots.
- R13: A one-slot frame (cfg_last_slot_i = 0) receives, transmits and generates sync every 8 bit clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ext_sync_i | input | 1 | 0: generate frame sync, 1: follow fs_i |
| cfg_last_slot_i | input | 7 | Number of slots per frame minus one |
| rx_mask_i | input | 128 | Receive enable per slot |
| tx_mask_i | input | 128 | Transmit enable per slot |
| bclk_i | input | 1 | Serial bit clock |
| fs_i | input | 1 | External frame sync |
| fs_o | output | 1 | Generated frame sync |
| tdm_rx_i | input | 1 | Serial receive data |
| tdm_tx_o | output | 1 | Serial transmit data |
| tdm_tx_oe_o | output | 1 | Transmit output enable for the pad |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_data_o | output | 8 | Received byte |
| rx_slot_o | output | 7 | Slot of received byte |
| tx_valid_i | input | 1 | Transmit stream byte available |
| tx_data_i | input | 8 | Transmit stream byte |
| tx_ready_o | output | 1 | Transmit stream byte taken this cycle |

## Verification
The hardest case to reach from the ports is an external sync pulse arriving mid-slot, in a slot that is active for both receive and transmit. The bench runs two regular externally synced frames and then raises fs_i at bit 4 of slot 2. It expects the partial receive byte to vanish and the partly sent transmit byte to be discarded. The following frames must then line up again byte for byte. A pre-lock stretch of unsynced bits with noise on the receive line also shows that the port stays silent until the first pulse.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = 3;
  typedef logic [BYTE_W-1:0] tdm_byte_t;
  typedef logic [BIT_W-1:0]  tdm_bit_t;
  localparam tdm_bit_t MSB_POS = tdm_bit_t'(BYTE_W - 1);
  typedef enum logic {SYNC_INT = 1'b0, SYNC_EXT = 1'b1} sync_src_e;
endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic sd_i,
  input  logic fs_i,
  output logic rise_o,
  output logic fall_o,
  output logic sd_o,
  output logic fs_o
);
  logic [STAGES-1:0] bclk_q, sd_q, fs_q;
  logic bclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= '0;
      sd_q   <= '0;
      fs_q   <= '0;
      bclk_d <= 1'b0;
    end else begin
      bclk_q <= {bclk_q[STAGES-2:0], bclk_i};
      sd_q   <= {sd_q[STAGES-2:0], sd_i};
      fs_q   <= {fs_q[STAGES-2:0], fs_i};
      bclk_d <= bclk_q[STAGES-1];
    end
  end

  // data and sync stay aligned with the synchronized bit clock
  assign rise_o = bclk_q[STAGES-1] & ~bclk_d;
  assign fall_o = ~bclk_q[STAGES-1] & bclk_d;
  assign sd_o   = sd_q[STAGES-1];
  assign fs_o   = fs_q[STAGES-1];
endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
  import tdm_pkg::*;
#(
  parameter int MAX_SLOTS = 128,
  parameter int SLOT_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              fs_i,
  input  logic              ext_i,
  input  logic [SLOT_W-1:0] last_i,
  output logic [SLOT_W-1:0] slot_o,
  output tdm_bit_t          bit_o,
  output logic [SLOT_W-1:0] nxt_slot_o,
  output tdm_bit_t          nxt_bit_o,
  output logic              run_o,
  output logic              step_o,
  output logic              fs_gen_o
);
  logic [SLOT_W-1:0] slot_q, nxt_slot;
  tdm_bit_t          pos_q, nxt_pos;
  logic              run_q, resync_q, fs_q, step;

  always_comb begin
    if (resync_q) begin
      nxt_slot = '0;
      nxt_pos  = MSB_POS;
    end else if (pos_q == '0) begin
      nxt_pos  = MSB_POS;
      nxt_slot = (slot_q >= last_i) ? '0 : slot_q + SLOT_W'(1);
    end else begin
      nxt_pos  = pos_q - tdm_bit_t'(1);
      nxt_slot = slot_q;
    end
  end

  // external mode holds still until the first sync is seen
  assign step = rise_i && (!ext_i || run_q || resync_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= SLOT_W'(MAX_SLOTS - 1);
      pos_q    <= '0;
      run_q    <= 1'b0;
      resync_q <= 1'b0;
      fs_q     <= 1'b0;
    end else begin
      if (fall_i && ext_i && fs_i)
        resync_q <= 1'b1;
      else if (step)
        resync_q <= 1'b0;
      if (step) begin
        slot_q <= nxt_slot;
        pos_q  <= nxt_pos;
        run_q  <= 1'b1;
        fs_q   <= !ext_i && (nxt_pos == '0) && (nxt_slot == last_i);
      end
    end
  end

  assign slot_o     = slot_q;
  assign bit_o      = pos_q;
  assign nxt_slot_o = nxt_slot;
  assign nxt_bit_o  = nxt_pos;
  assign run_o      = run_q;
  assign step_o     = step;
  assign fs_gen_o   = fs_q;
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
  import tdm_pkg::*;
#(
  parameter int MAX_SLOTS = 128,
  parameter int SLOT_W    = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fall_i,
  input  logic                 run_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  tdm_bit_t             bit_i,
  input  logic                 sd_i,
  input  logic [MAX_SLOTS-1:0] mask_i,
  output logic                 valid_o,
  output tdm_byte_t            data_o,
  output logic [SLOT_W-1:0]    slot_o
);
  tdm_byte_t         sh_q, data_q;
  logic [SLOT_W-1:0] slot_q;
  logic              valid_q, take;

  assign take = fall_i && run_i && mask_i[slot_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_q  <= '0;
      slot_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (take) begin
        sh_q <= {sh_q[BYTE_W-2:0], sd_i};
        if (bit_i == '0) begin
          data_q  <= {sh_q[BYTE_W-2:0], sd_i};
          slot_q  <= slot_i;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign slot_o  = slot_q;
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
  import tdm_pkg::*;
#(
  parameter int MAX_SLOTS = 128,
  parameter int SLOT_W    = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic [SLOT_W-1:0]    nxt_slot_i,
  input  tdm_bit_t             nxt_bit_i,
  input  logic [MAX_SLOTS-1:0] mask_i,
  input  logic                 valid_i,
  input  tdm_byte_t            data_i,
  output logic                 ready_o,
  output logic                 sd_o,
  output logic                 oe_o
);
  tdm_byte_t sh_q;
  logic      oe_q, load;

  assign load    = step_i && (nxt_bit_i == MSB_POS) && mask_i[nxt_slot_i];
  assign ready_o = load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (step_i) begin
      oe_q <= mask_i[nxt_slot_i];
      if (load)
        sh_q <= valid_i ? data_i : '0; // underrun sends zeros
      else
        sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign sd_o = oe_q & sh_q[BYTE_W-1];
  assign oe_o = oe_q;
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
  import tdm_pkg::*;
#(
  parameter int MAX_SLOTS   = 128,
  parameter int SYNC_STAGES = 2,
  localparam int SLOT_W     = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_ext_sync_i,
  input  logic [SLOT_W-1:0]    cfg_last_slot_i,
  input  logic [MAX_SLOTS-1:0] rx_mask_i,
  input  logic [MAX_SLOTS-1:0] tx_mask_i,
  input  logic                 bclk_i,
  input  logic                 fs_i,
  output logic                 fs_o,
  input  logic                 tdm_rx_i,
  output logic                 tdm_tx_o,
  output logic                 tdm_tx_oe_o,
  output logic                 rx_valid_o,
  output logic [BYTE_W-1:0]    rx_data_o,
  output logic [SLOT_W-1:0]    rx_slot_o,
  input  logic                 tx_valid_i,
  input  logic [BYTE_W-1:0]    tx_data_i,
  output logic                 tx_ready_o
);
  sync_src_e         src;
  logic              ext;
  logic              bclk_rise, bclk_fall, rx_sd, fs_s;
  logic [SLOT_W-1:0] cur_slot, nxt_slot;
  tdm_bit_t          cur_bit, nxt_bit;
  logic              run, step;

  assign src = sync_src_e'(cfg_ext_sync_i);
  assign ext = (src == SYNC_EXT);

  tdm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_i (bclk_i),
    .sd_i   (tdm_rx_i),
    .fs_i   (fs_i),
    .rise_o (bclk_rise),
    .fall_o (bclk_fall),
    .sd_o   (rx_sd),
    .fs_o   (fs_s)
  );

  tdm_frame_ctr #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (bclk_rise),
    .fall_i     (bclk_fall),
    .fs_i       (fs_s),
    .ext_i      (ext),
    .last_i     (cfg_last_slot_i),
    .slot_o     (cur_slot),
    .bit_o      (cur_bit),
    .nxt_slot_o (nxt_slot),
    .nxt_bit_o  (nxt_bit),
    .run_o      (run),
    .step_o     (step),
    .fs_gen_o   (fs_o)
  );

  tdm_rx_lane #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (bclk_fall),
    .run_i   (run),
    .slot_i  (cur_slot),
    .bit_i   (cur_bit),
    .sd_i    (rx_sd),
    .mask_i  (rx_mask_i),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .slot_o  (rx_slot_o)
  );

  tdm_tx_lane #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .nxt_slot_i (nxt_slot),
    .nxt_bit_i  (nxt_bit),
    .mask_i     (tx_mask_i),
    .valid_i    (tx_valid_i),
    .data_i     (tx_data_i),
    .ready_o    (tx_ready_o),
    .sd_o       (tdm_tx_o),
    .oe_o       (tdm_tx_oe_o)
  );
endmodule

// File: rtl/tdm_slot_port_chk.sv
module tdm_slot_port_chk #(
  parameter int MAX_SLOTS = 128,
  parameter int SLOT_W    = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_ext_sync_i,
  input logic [SLOT_W-1:0]    cfg_last_slot_i,
  input logic [MAX_SLOTS-1:0] rx_mask_i,
  input logic                 rx_valid_i,
  input logic [SLOT_W-1:0]    rx_slot_i,
  input logic                 tx_ready_i,
  input logic                 tx_sd_i,
  input logic                 tx_oe_i,
  input logic                 fs_gen_i,
  input logic                 bclk_rise_i
);
  p_rx_slot_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> (rx_slot_i <= cfg_last_slot_i));

  p_rx_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !rx_valid_i);

  p_rx_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> rx_mask_i[rx_slot_i]);

  p_tx_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bclk_rise_i |=> ($stable(tx_sd_i) && $stable(tx_oe_i)));

  p_ready_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_i |=> tx_oe_i);

  p_ext_no_fs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ext_sync_i |-> !fs_gen_i);
endmodule

bind tdm_slot_port tdm_slot_port_chk #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cfg_ext_sync_i  (cfg_ext_sync_i),
  .cfg_last_slot_i (cfg_last_slot_i),
  .rx_mask_i       (rx_mask_i),
  .rx_valid_i      (rx_valid_o),
  .rx_slot_i       (rx_slot_o),
  .tx_ready_i      (tx_ready_o),
  .tx_sd_i         (tdm_tx_o),
  .tx_oe_i         (tdm_tx_oe_o),
  .fs_gen_i        (fs_o),
  .bclk_rise_i     (bclk_rise)
);

// File: tb/sim_tdm_slot_port.sv
module sim_tdm_slot_port;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_ni = 1'b0;
  logic         cfg_ext = 1'b0;
  logic [6:0]   cfg_last = '0;
  logic [127:0] rxm = '0, txm = '0;
  logic         bclk_i = 1'b0, fs_i = 1'b0, tdm_rx_i = 1'b0;
  logic         fs_o, tdm_tx_o, tdm_tx_oe_o, rx_valid_o, tx_ready_o;
  logic [7:0]   rx_data_o;
  logic [6:0]   rx_slot_o;
  logic         tx_valid_i = 1'b1;
  logic [7:0]   tx_data_i = 8'hC3;

  tdm_slot_port #(.MAX_SLOTS(128)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_ext_sync_i(cfg_ext), .cfg_last_slot_i(cfg_last),
    .rx_mask_i(rxm), .tx_mask_i(txm), .bclk_i(bclk_i), .fs_i(fs_i), .fs_o(fs_o),
    .tdm_rx_i(tdm_rx_i), .tdm_tx_o(tdm_tx_o), .tdm_tx_oe_o(tdm_tx_oe_o),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_slot_o(rx_slot_o),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i), .tx_ready_o(tx_ready_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int rx_sq[$];
  logic [7:0] rx_dq[$];
  logic [7:0] tx_q[$];
  int ready_cnt = 0, exp_ready = 0, fs_hits = 0;
  int b_slot = 0, b_bit = 7, fr = 0;
  logic [7:0] acc = '0;
  logic oe_all = 1'b1, oe_any = 1'b0, tx_any = 1'b0, under = 1'b0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int s);
    return 8'((s * 29 + f * 71 + 90) % 256);
  endfunction

  task automatic do_reset(input logic e, input logic [6:0] l, input logic [127:0] rm,
                          input logic [127:0] tm);
    @(negedge clk);
    rst_ni = 1'b0; bclk_i = 1'b0; fs_i = 1'b0; tdm_rx_i = 1'b0;
    cfg_ext = e; cfg_last = l; rxm = rm; txm = tm; tx_valid_i = 1'b1; under = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({rx_valid_o, tx_ready_o, tdm_tx_o, tdm_tx_oe_o, fs_o} == 5'b0, "R1 reset outputs",
        int'({rx_valid_o, tx_ready_o, tdm_tx_o, tdm_tx_oe_o, fs_o}), 0);
    rx_sq.delete(); rx_dq.delete(); tx_q.delete();
    ready_cnt = 0; exp_ready = 0; fs_hits = 0;
    b_slot = 0; b_bit = 7; fr = 0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // one bit period as seen by the far end of the line
  task automatic bit_cycle(input logic fsv, input logic trk, input logic early);
    logic [7:0] b;
    logic [7:0] e;
    @(negedge clk);
    bclk_i = 1'b1;
    fs_i = fsv;
    b = pat(fr, b_slot);
    if (trk && rxm[b_slot]) tdm_rx_i = b[b_bit];
    else tdm_rx_i = ~tdm_rx_i;
    if (trk && rxm[b_slot] && b_bit == 0) begin
      rx_sq.push_back(b_slot);
      rx_dq.push_back(b);
    end
    if (trk && txm[b_slot] && b_bit == 7) exp_ready++;
    repeat (HALF) @(negedge clk);
    if (fs_o) fs_hits++;
    if (trk) begin
      if (b_bit == 7) begin acc = '0; oe_all = 1'b1; oe_any = 1'b0; tx_any = 1'b0; end
      acc = {acc[6:0], tdm_tx_o};
      oe_all &= tdm_tx_oe_o; oe_any |= tdm_tx_oe_o; tx_any |= tdm_tx_o;
      chk(fs_o == (!cfg_ext && b_bit == 0 && b_slot == int'(cfg_last)), "R9 fs_o per bit",
          int'(fs_o), int'(!cfg_ext && b_bit == 0 && b_slot == int'(cfg_last)));
      if (b_bit == 0) begin
        if (txm[b_slot]) begin
          e = (tx_q.size() > 0) ? tx_q.pop_front() : 8'h00;
          chk(acc == e, under ? "R8 underrun byte" : "R6/R12 tx byte MSB first", acc, e);
          chk(oe_all, "R7 oe held in active slot", oe_all, 1);
        end else begin
          chk(!oe_any && !tx_any, "R7/R12 idle tx slot", {oe_any, tx_any}, 0);
        end
      end
      if (early) begin
        if (txm[b_slot] && tx_q.size() > 0) void'(tx_q.pop_front());
      end
    end else begin
      chk(!tdm_tx_oe_o && !fs_o, "R11 idle before first sync", {tdm_tx_oe_o, fs_o}, 0);
    end
    bclk_i = 1'b0;
    repeat (HALF - 1) @(negedge clk);
    if (trk) begin
      if (early || (b_bit == 0 && b_slot == int'(cfg_last))) begin
        b_slot = 0; b_bit = 7; fr++;
      end else if (b_bit == 0) begin
        b_slot++; b_bit = 7;
      end else b_bit--;
    end
  endtask

  task automatic run_frames(input int n);
    for (int i = 0; i < n * (int'(cfg_last) + 1) * 8; i++)
      bit_cycle(cfg_ext && b_slot == int'(cfg_last) && b_bit == 0, 1'b1, 1'b0);
  endtask

  task automatic end_phase(input string tag);
    repeat (20) @(negedge clk);
    chk(rx_sq.size() == 0, "R4 all rx bytes delivered", rx_sq.size(), 0);
    chk(tx_q.size() == 0, "R6 all tx bytes sent", tx_q.size(), 0);
    chk(ready_cnt == exp_ready, tag, ready_cnt, exp_ready);
  endtask

  // monitor: received bytes against the scoreboard
  initial forever begin
    @(negedge clk);
    if (rx_valid_o) begin
      if (rx_sq.size() == 0) begin
        chk(1'b0, "R5/R10 unexpected rx byte", rx_slot_o, -1);
      end else begin
        int s;
        logic [7:0] d;
        s = rx_sq.pop_front();
        d = rx_dq.pop_front();
        chk(int'(rx_slot_o) == s, "R4 rx slot", rx_slot_o, s);
        chk(rx_data_o == d, "R3 rx byte MSB first", rx_data_o, d);
      end
    end
  end

  // stream driver: records each byte the port takes, then presents the next
  initial forever begin
    @(negedge clk);
    if (tx_ready_o && rst_ni) begin
      ready_cnt++;
      if (tx_valid_i) begin
        tx_q.push_back(tx_data_i);
        @(posedge clk);
        #1;
        tx_data_i = tx_data_i + 8'h3B;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] m1, m2;
    // P1: 4 slots, scattered independent masks (R12)
    m1 = '0; m1[1] = 1'b1; m1[3] = 1'b1;
    m2 = '0; m2[0] = 1'b1; m2[2] = 1'b1;
    do_reset(1'b0, 7'd3, m1, m2);
    run_frames(3);
    end_phase("R6 ready pulses 4-slot");
    chk(fs_hits == 3, "R9 fs count 4-slot", fs_hits, 3);

    // P2: full 128-slot frame (R2)
    m1 = '0; m1[0] = 1'b1; m1[5] = 1'b1; m1[64] = 1'b1; m1[127] = 1'b1;
    m2 = '0; m2[1] = 1'b1; m2[64] = 1'b1; m2[126] = 1'b1; m2[127] = 1'b1;
    do_reset(1'b0, 7'd127, m1, m2);
    run_frames(2);
    end_phase("R2 ready pulses 128-slot");
    chk(fs_hits == 2, "R2 frame length 128 slots", fs_hits, 2);

    // P3: single slot, with an underrun frame (R13, R8)
    m1 = '0; m1[0] = 1'b1;
    do_reset(1'b0, 7'd0, m1, m1);
    run_frames(2);
    tx_valid_i = 1'b0; under = 1'b1;
    run_frames(1);
    tx_valid_i = 1'b1; under = 1'b0;
    run_frames(2);
    end_phase("R8 ready pulses with underrun");
    chk(fs_hits == 5, "R13 one-slot frame sync count", fs_hits, 5);

    // P4: external sync, pre-lock idle, then a mid-frame resync (R10, R11)
    m1 = '0; m1[0] = 1'b1; m1[2] = 1'b1; m1[5] = 1'b1;
    m2 = '0; m2[1] = 1'b1; m2[2] = 1'b1; m2[4] = 1'b1;
    do_reset(1'b1, 7'd5, m1, m2);
    for (int i = 0; i < 11; i++) bit_cycle(1'b0, 1'b0, 1'b0);
    bit_cycle(1'b1, 1'b0, 1'b0);
    chk(ready_cnt == 0, "R11 no stream use before lock", ready_cnt, 0);
    run_frames(2);
    while (!(b_slot == 2 && b_bit == 4)) bit_cycle(1'b0, 1'b1, 1'b0);
    bit_cycle(1'b1, 1'b1, 1'b1);
    run_frames(2);
    end_phase("R10 ready pulses after resync");
    chk(fs_hits == 0, "R9 no fs_o in external mode", fs_hits, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule